// File: doc/BRIEF.md
# Unsigned Q8.8 Fixed-Point Multiplier with Narrowing Flags

This block multiplies two unsigned fixed-point numbers, each holding 8 integer bits above 8 fraction bits. It returns the exact double-width product, which has 16 integer bits above 16 fraction bits. It also returns a copy of the product narrowed back to the operand format, together with two flags. The flags tell the consumer whether that narrowed copy lost integer weight or fraction weight.

The block is purely combinational and has no clock, reset or handshake. Every output is a function of the two operands alone and follows them within the same evaluation. A consumer that needs exact arithmetic reads the wide product. A consumer that stays in the operand format reads the narrowed product and checks the flags before it trusts that value. The narrowed value truncates, so any fraction weight below the operand's least significant bit is dropped, which rounds toward zero.

Top module: `fxq_mul`

## Requirements
- R1: `prod_full_o` equals the exact unsigned product of `op_a_i` and `op_b_i` taken as 32-bit integers. Bits [31:16] are the integer part and bits [15:0] are the fraction part.
- R2: `prod_q_o` equals bits [23:8] of the full product. This is the product in the operand's 8.8 layout, truncated toward zero.
- R3: `ovf_o` is 1 exactly when the full product is at or above 2^24, that is, when any of bits [31:24] is set. Otherwise it is 0.
- R4: `lost_o` is 1 exactly when any of bits [7:0] of the full product is set. Otherwise it is 0.
- R5: When either operand is zero, both product outputs are zero and both flags are 0.
- R6: When one operand is 0x0100 (the value 1.0), `prod_q_o` equals the other operand, `prod_full_o` equals that operand shifted left by 8, and both flags are 0.
- R7: The outputs depend only on the present operands. A new operand pair is fully reflected at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 16 | First operand, unsigned 8.8 |
| op_b_i | input | 16 | Second operand, unsigned 8.8 |
| prod_full_o | output | 32 | Exact product, unsigned 16.16 |
| prod_q_o | output | 16 | Product narrowed to 8.8 by truncation |
| ovf_o | output | 1 | Integer part too large for the narrowed product |
| lost_o | output | 1 | Nonzero fraction bits were discarded |

## Verification
Directed pairs isolate each flag:
- 1.5 times 1.5 sets neither flag.
- 16 times 16 sets only the overflow flag.
- The smallest fraction squared sets only the precision-lost flag.
- All-ones squared sets both flags.

Zero and unity operands on either side show whether both multiplier inputs take part symmetrically and whether the narrowing window sits at the right bit offset. Seeded random pairs, some restricted to small magnitudes, cover carries through every partial-product row. Each output is compared against a bench model that forms the product with the language's own multiply. Operands are changed in the middle of a clock period to show that the outputs follow with no clock edge.

// File: rtl/fxq_pkg.sv
package fxq_pkg;
  parameter int unsigned FXQ_INT_W  = 8;
  parameter int unsigned FXQ_FRAC_W = 8;

  typedef struct packed {
    logic ovf;
    logic lost;
  } fxq_flags_t;
endpackage

// File: rtl/fxq_pp_array.sv
module fxq_pp_array #(
  parameter int OP_W = 16,
  localparam int PW = 2 * OP_W
) (
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic [PW-1:0]   prod_o
);
  logic [PW-1:0] acc [0:OP_W];

  assign acc[0] = '0;

  genvar r;
  generate
    for (r = 0; r < OP_W; r++) begin : g_row
      logic [PW-1:0] row;
      assign row        = b_i[r] ? (PW'(a_i) << r) : '0;
      assign acc[r + 1] = acc[r] + row;
    end
  endgenerate

  assign prod_o = acc[OP_W];

  always_comb begin
    // R1
    full_prod_chk: assert (prod_o == PW'(a_i) * PW'(b_i));
    // R5
    zero_op_chk: assert (!((a_i == '0) || (b_i == '0)) || (prod_o == '0));
  end
endmodule

// File: rtl/fxq_slice.sv
module fxq_slice #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 8,
  localparam int OP_W = INT_W + FRAC_W,
  localparam int PW   = 2 * OP_W
) (
  input  logic [PW-1:0]   prod_i,
  output logic [OP_W-1:0] q_o
);
  assign q_o = prod_i[FRAC_W +: OP_W];

  always_comb begin
    // R2
    slice_pos_chk: assert (q_o == OP_W'(prod_i >> FRAC_W));
  end
endmodule

// File: rtl/fxq_flag_gen.sv
module fxq_flag_gen
  import fxq_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 8,
  localparam int OP_W = INT_W + FRAC_W,
  localparam int PW   = 2 * OP_W
) (
  input  logic [PW-1:0] prod_i,
  output fxq_flags_t    flags_o
);
  localparam logic [PW-1:0] LIMIT = {{INT_W{1'b0}}, {(OP_W + FRAC_W){1'b1}}};

  assign flags_o.ovf  = |prod_i[PW-1 -: INT_W];
  assign flags_o.lost = |prod_i[FRAC_W-1:0];

  always_comb begin
    // R3
    no_overflow_chk: assert (flags_o.ovf == (prod_i > LIMIT));
    // R4
    lost_bits_chk: assert (flags_o.lost == (((prod_i >> FRAC_W) << FRAC_W) != prod_i));
  end
endmodule

// File: rtl/fxq_mul.sv
module fxq_mul
  import fxq_pkg::*;
#(
  parameter int INT_W  = FXQ_INT_W,
  parameter int FRAC_W = FXQ_FRAC_W,
  localparam int OP_W = INT_W + FRAC_W,
  localparam int PW   = 2 * OP_W
) (
  input  logic [OP_W-1:0] op_a_i,
  input  logic [OP_W-1:0] op_b_i,
  output logic [PW-1:0]   prod_full_o,
  output logic [OP_W-1:0] prod_q_o,
  output logic            ovf_o,
  output logic            lost_o
);
  localparam logic [OP_W-1:0] UNITY = OP_W'(1) << FRAC_W;

  logic [PW-1:0] prod;
  fxq_flags_t    flags;

  fxq_pp_array #(.OP_W(OP_W)) u_pp (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .prod_o(prod)
  );

  fxq_slice #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_slice (
    .prod_i(prod),
    .q_o   (prod_q_o)
  );

  fxq_flag_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_flags (
    .prod_i (prod),
    .flags_o(flags)
  );

  assign prod_full_o = prod;
  assign ovf_o       = flags.ovf;
  assign lost_o      = flags.lost;

  always_comb begin
    // R6
    unity_chk: assert (!(op_b_i == UNITY) || ((prod_q_o == op_a_i) && !ovf_o && !lost_o));
    // R5
    zero_flags_chk: assert (!((op_a_i == '0) || (op_b_i == '0)) || (!ovf_o && !lost_o && prod_q_o == '0));
  end
endmodule

// File: tb/test_fxq_mul.sv
module test_fxq_mul;
  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic [31:0] full;
  logic [15:0] q;
  logic        ovf, lost;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fxq_mul i_fxq_mul (
    .op_a_i(a), .op_b_i(b), .prod_full_o(full),
    .prod_q_o(q), .ovf_o(ovf), .lost_o(lost)
  );

  function automatic logic [31:0] exp_full(logic [15:0] x, logic [15:0] y);
    return {16'h0, x} * {16'h0, y};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] x, logic [15:0] y);
    logic [31:0] e;
    @(negedge clk);
    a = x; b = y;
    #1;
    e = exp_full(x, y);
    check("R1", full, e);
    check("R2", {16'h0, q}, {16'h0, e[23:8]});
    check("R3", {31'h0, ovf}, {31'h0, (e >= 32'h0100_0000)});
    check("R4", {31'h0, lost}, {31'h0, (e[7:0] != 8'h0)});
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    a = 16'h0; b = 16'h0;
    void'($urandom(32'd1234));
    #1;
    // R5: reset-time state with zero operands
    check("R5", full, 32'h0);
    check("R5", {31'h0, ovf | lost}, 32'h0);
    apply(16'h0000, 16'hFFFF);
    check("R5", {16'h0, q}, 32'h0);
    apply(16'hABCD, 16'h0000);
    check("R5", {30'h0, ovf, lost}, 32'h0);
    // R6: unity on either side
    apply(16'h0100, 16'hABCD);
    check("R6", {16'h0, q}, 32'h0000_ABCD);
    check("R6", full, 32'h00AB_CD00);
    apply(16'h9F31, 16'h0100);
    check("R6", {16'h0, q}, 32'h0000_9F31);
    check("R6", {30'h0, ovf, lost}, 32'h0);
    apply(16'h0180, 16'h0180);
    check("R2", {16'h0, q}, 32'h0000_0240);
    apply(16'h1000, 16'h1000);
    check("R3", {30'h0, ovf, lost}, 32'h2);
    apply(16'h0001, 16'h0001);
    check("R4", {30'h0, ovf, lost}, 32'h1);
    apply(16'hFFFF, 16'hFFFF);
    check("R3", {30'h0, ovf, lost}, 32'h3);
    apply(16'h0FFF, 16'h0010);
    // R7: operands change mid-cycle, outputs follow without an edge
    @(posedge clk);
    #1 a = 16'h0200; b = 16'h0300;
    #0.5;
    check("R7", full, 32'h0006_0000);
    check("R7", {16'h0, q}, 32'h0000_0600);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] x, y;
      x = 16'($urandom());
      y = 16'($urandom());
      if (i % 3 == 0) begin
        x = {8'h0, x[7:0]} | 16'h0100 * 16'(x[8]);
        y = y & 16'h0FFF;
      end
      apply(x, y);
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule